// File: doc/BRIEF.md
# Load/Store Address Generator

This block works out where a load or store goes and what the base register should become afterwards. A request brings a base value and an offset. The offset is one of three kinds: a constant carried with the instruction, a raw register value, or a register value passed through a barrel shifter. A direction bit says whether the offset is added to the base or subtracted from it. A timing-mode select then decides two things: which value goes onto the bus, and which value, if any, is written back to the base register.

All results are registered. One cycle after a request is accepted, a valid strobe rises together with the bus address, the writeback enable and the writeback value. Back-to-back requests are accepted on every clock.

Top module: `ls_agu`

## Requirements
- R1: Synchronous active-high reset clears `res_valid` to 0. With no request, `res_valid` is 0 in the following cycle.
- R2: When `req_valid` is 1 at a clock edge, `res_valid` is 1 after that edge and the other outputs hold the result for that request. Otherwise `res_valid` is 0 after the edge.
- R3: Offset kind `ofs_kind`: 0 uses `imm_ofs` zero-extended to 32 bits, 1 uses `reg_ofs` unshifted, 2 uses `reg_ofs` shifted. Code 3 behaves as code 1.
- R4: Shift kind `shk` for the shifted form: 0 is logical left, 1 is logical right, 2 is arithmetic right, 3 is rotate right, each by `shamt` (0 to 31). A `shamt` of 0 passes the register unchanged for every shift kind.
- R5: When `add_n_sub` is 1 the sum is base plus offset. When it is 0 the sum is base minus offset. Both wrap modulo 2^32.
- R6: Mode `idx` 0 (plain offset): `res_addr` is the sum and `res_wb_en` is 0.
- R7: Mode `idx` 1 (update before): `res_addr` and `res_wb_val` both equal the sum, and `res_wb_en` is 1.
- R8: Mode `idx` 2 (update after): `res_addr` is the unmodified base, `res_wb_val` is the sum, and `res_wb_en` is 1. Code 3 behaves as code 0.
- R9: Base 0x1009C with immediate 4 in mode 1 gives address 0x100A0 and writeback 0x100A0. Following that with base 0x100A0, immediate 4, mode 2 gives address 0x100A0 and writeback 0x100A4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe |
| base | input | 32 | Base register value |
| imm_ofs | input | 12 | Immediate offset, zero-extended |
| reg_ofs | input | 32 | Offset register value |
| ofs_kind | input | 2 | Offset source select |
| shk | input | 2 | Shift kind |
| shamt | input | 5 | Shift amount |
| add_n_sub | input | 1 | 1 add, 0 subtract |
| idx | input | 2 | Indexing mode |
| res_valid | output | 1 | Result valid, one cycle after request |
| res_addr | output | 32 | Bus address |
| res_wb_en | output | 1 | Base writeback enable |
| res_wb_val | output | 32 | Base writeback value |

## Verification
Two functions can act in the same cycle: the shifter that scales the offset and the subtract path of the adder. Requests that use the shifted offset form with a non-zero shift and `add_n_sub` at 0 make both of them act together. Large shift amounts and bases near zero are included so that the shifted offset goes past the base and the result has to wrap. Every cycle, the bench reference model computes the shift with plain operators and the wrap with a 33-bit sum truncated to 32 bits, and it compares all four outputs against those values.

// File: rtl/ls_agu_pkg.sv
package ls_agu_pkg;
  typedef enum logic [1:0] {OFS_IMM = 2'd0, OFS_REG = 2'd1, OFS_SCL = 2'd2, OFS_RSV = 2'd3} ofs_kind_e;
  typedef enum logic [1:0] {SH_LSL = 2'd0, SH_LSR = 2'd1, SH_ASR = 2'd2, SH_ROR = 2'd3} sh_kind_e;
  typedef enum logic [1:0] {IX_OFS = 2'd0, IX_PRE = 2'd1, IX_POST = 2'd2, IX_RSV = 2'd3} idx_e;
endpackage

// File: rtl/ls_agu_shift.sv
module ls_agu_shift #(
  parameter int W = 32,
  localparam int SW = $clog2(W)
) (
  input  logic [W-1:0]  din,
  input  logic [1:0]    kind,
  input  logic [SW-1:0] amt,
  output logic [W-1:0]  dout
);
  import ls_agu_pkg::*;
  logic [W-1:0] stg [SW+1];
  logic         fill;

  assign stg[0] = din;
  assign fill   = (sh_kind_e'(kind) == SH_ASR) ? din[W-1] : 1'b0;

  for (genvar s = 0; s < SW; s++) begin : g_stage
    localparam int D = 1 << s;
    always_comb begin
      stg[s+1] = stg[s];
      if (amt[s]) begin
        case (sh_kind_e'(kind))
          SH_LSL:  stg[s+1] = {stg[s][W-1-D:0], {D{1'b0}}};
          SH_ROR:  stg[s+1] = {stg[s][D-1:0], stg[s][W-1:D]};
          default: stg[s+1] = {{D{fill}}, stg[s][W-1:D]};
        endcase
      end
    end
  end

  assign dout = stg[SW];
endmodule

// File: rtl/ls_agu_sum.sv
module ls_agu_sum #(
  parameter int W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         add,
  output logic [W-1:0] s
);
  logic [W:0] full;
  assign full = {1'b0, a} + {1'b0, add ? b : ~b} + {{W{1'b0}}, ~add};
  assign s = full[W-1:0];
endmodule

// File: rtl/ls_agu.sv
module ls_agu #(
  parameter int AW = 32,
  parameter int IW = 12,
  localparam int SW = $clog2(AW)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_valid,
  input  logic [AW-1:0] base,
  input  logic [IW-1:0] imm_ofs,
  input  logic [AW-1:0] reg_ofs,
  input  logic [1:0]    ofs_kind,
  input  logic [1:0]    shk,
  input  logic [SW-1:0] shamt,
  input  logic          add_n_sub,
  input  logic [1:0]    idx,
  output logic          res_valid,
  output logic [AW-1:0] res_addr,
  output logic          res_wb_en,
  output logic [AW-1:0] res_wb_val
);
  import ls_agu_pkg::*;

  logic [AW-1:0] shifted, ofs, sum;

  ls_agu_shift #(.W(AW)) u_shift (
    .din(reg_ofs), .kind(shk), .amt(shamt), .dout(shifted));

  always_comb begin
    case (ofs_kind_e'(ofs_kind))
      OFS_IMM: ofs = {{(AW-IW){1'b0}}, imm_ofs};
      OFS_SCL: ofs = shifted;
      default: ofs = reg_ofs;
    endcase
  end

  ls_agu_sum #(.W(AW)) u_sum (.a(base), .b(ofs), .add(add_n_sub), .s(sum));

  always_ff @(posedge clk) begin
    if (rst) begin
      res_valid  <= 1'b0;
      res_addr   <= '0;
      res_wb_en  <= 1'b0;
      res_wb_val <= '0;
    end else begin
      res_valid <= req_valid;
      if (req_valid) begin
        res_wb_val <= sum;
        case (idx_e'(idx))
          IX_PRE:  begin res_addr <= sum;  res_wb_en <= 1'b1; end
          IX_POST: begin res_addr <= base; res_wb_en <= 1'b1; end
          default: begin res_addr <= sum;  res_wb_en <= 1'b0; end
        endcase
      end
    end
  end

  p_strobe_r2: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> res_valid);
  p_idle_r1: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !res_valid);
  p_pre_r7: assert property (@(posedge clk) disable iff (rst)
    (req_valid && idx == 2'd1) |=> (res_wb_en && res_addr == res_wb_val));
  p_post_r8: assert property (@(posedge clk) disable iff (rst)
    (req_valid && idx == 2'd2) |=> (res_wb_en && res_addr == $past(base)));
  p_ofs_r6: assert property (@(posedge clk) disable iff (rst)
    (req_valid && (idx == 2'd0 || idx == 2'd3)) |=> !res_wb_en);
  p_zero_r4: assert property (@(posedge clk) disable iff (rst)
    (req_valid && ofs_kind == 2'd2 && shamt == '0 && add_n_sub && idx == 2'd0)
      |=> res_addr == $past(base) + $past(reg_ofs));
endmodule

// File: tb/ls_agu_bench.sv
module ls_agu_bench;
  logic clk = 0, rst = 1, req_valid = 0, add_n_sub = 0;
  logic [31:0] base = 0, reg_ofs = 0;
  logic [11:0] imm_ofs = 0;
  logic [1:0] ofs_kind = 0, shk = 0, idx = 0;
  logic [4:0] shamt = 0;
  logic res_valid, res_wb_en;
  logic [31:0] res_addr, res_wb_val;
  int checks = 0, errors = 0;
  logic        e_v = 0, e_wen = 0;
  logic [31:0] e_addr = 0, e_wb = 0;

  always #2 clk = ~clk;

  ls_agu u_ls_agu (.*);

  function automatic logic [31:0] ref_off(logic [1:0] k, logic [11:0] im, logic [31:0] r,
                                          logic [1:0] sk, logic [4:0] a);
    logic [63:0] dbl;
    if (k == 0) return {20'd0, im};
    if (k != 2) return r;
    case (sk)
      0: return r << a;
      1: return r >> a;
      2: return $signed(r) >>> a;
      default: begin dbl = {r, r} >> a; return dbl[31:0]; end
    endcase
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic drive(logic v, logic [31:0] b, logic [11:0] im, logic [31:0] r,
                       logic [1:0] k, logic [1:0] sk, logic [4:0] a, logic ad, logic [1:0] ix);
    logic [32:0] s;
    logic [31:0] o;
    req_valid = v; base = b; imm_ofs = im; reg_ofs = r; ofs_kind = k;
    shk = sk; shamt = a; add_n_sub = ad; idx = ix;
    o = ref_off(k, im, r, sk, a);
    s = ad ? {1'b0, b} + {1'b0, o} : {1'b0, b} - {1'b0, o};
    e_v = v;
    if (v) begin
      e_wb = s[31:0];
      e_wen = (ix == 1 || ix == 2);
      e_addr = (ix == 2) ? b : s[31:0];
    end
    @(posedge clk); #1;
    chk("R2 valid", {31'd0, res_valid}, {31'd0, e_v});
    if (v) begin
      chk("R3-R8 addr", res_addr, e_addr);
      chk("R6 R7 R8 wb_en", {31'd0, res_wb_en}, {31'd0, e_wen});
      chk("R5 R7 R8 wb_val", res_wb_val, e_wb);
    end
  endtask

  initial begin
    #1000000;
    errors++; checks++;
    $display("FAIL watchdog act=hung exp=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] lfsr = 32'hACE1_1234;
    repeat (3) @(posedge clk);
    #1; rst = 0;
    chk("R1 reset", {31'd0, res_valid}, 32'd0);
    drive(0, 0, 0, 0, 0, 0, 0, 1, 0);
    // R9 worked pair
    drive(1, 32'h1009C, 12'd4, 0, 0, 0, 0, 1, 1);
    chk("R9 pre addr", res_addr, 32'h100A0);
    drive(1, 32'h100A0, 12'd4, 0, 0, 0, 0, 1, 2);
    chk("R9 post addr", res_addr, 32'h100A0);
    chk("R9 post wb", res_wb_val, 32'h100A4);
    // R4 scaled 3<<2
    drive(1, 32'h1009C, 0, 3, 2, 0, 2, 1, 0);
    chk("R4 scaled", res_addr, 32'h100A8);
    // R4 shamt 0 on each shift kind
    for (int k = 0; k < 4; k++) drive(1, 32'h10, 0, 32'h8000_0001, 2, k[1:0], 0, 1, 0);
    // R5 subtract wrap, R3 code 3
    drive(1, 32'h4, 0, 32'h10, 3, 0, 0, 0, 1);
    chk("R5 wrap", res_addr, 32'hFFFF_FFF4);
    drive(1, 32'hFFFF_FFFF, 12'hFFF, 0, 0, 0, 0, 1, 3);
    // R8 subtract with scaled
    drive(1, 32'h100, 0, 32'h8000_0000, 2, 2, 31, 0, 2);
    for (int i = 0; i < 300; i++) begin
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      drive(lfsr[3], {lfsr[15:0], lfsr[31:16]}, lfsr[11:0], lfsr ^ 32'h5A5A_0F0F,
            lfsr[5:4], lfsr[7:6], lfsr[12:8], lfsr[13], lfsr[15:14]);
    end
    rst = 1; @(posedge clk); #1;
    chk("R1 reset again", {31'd0, res_valid}, 32'd0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule